// File: doc/BRIEF.md
# Programmable-Length Manchester Frame Encoder

This block turns a data word, supplied one bit at a time by external logic, into a biphase (Manchester II) serial frame. Each frame has three parts. First comes a three-bit-period synchronisation waveform whose polarity marks the frame as a command or a data frame. Next come N data bits, most significant first. Last comes one parity bit. N is set at run time to any value from 2 to 28, so a frame lasts 6 to 32 bit periods. The parity sense, even or odd, is selectable.

The block runs from a single clock at twice the bit rate, so each clock is one half of a bit cell. A one-clock strobe asks the external logic for the next data bit, and the block samples the serial input at the end of the bit cell that holds the strobe. The line is driven by two complementary outputs, and an inhibit input can force both of them inactive. A free-running divide-by-six of the clock is also provided for neighbouring logic. While enable stays high, frames follow one another with no gap.

Top module: `manchester_frame_enc`

## Requirements
- R1: While rst is high, and at the first sample after it, line_one, line_zero, shift_stb and clk_div6 are all 0. A reset during a frame abandons that frame.
- R2: A frame starts on the first cell boundary after enable is sampled high. The first half-cell appears on the outputs at most two clocks after enable rises. Sync is three half-cells with line_one at the sync_kind level, then three half-cells at the opposite level. sync_kind=1 (command type) therefore starts high, and sync_kind=0 (data type) starts low. sync_kind is captured at frame start.
- R3: Data cells are sent most significant bit first, one clock per half-cell. For a 1, line_one is high in the first half and low in the second. For a 0, the halves are reversed.
- R4: word_len gives N. Values below 2 act as 2, and values above 28 act as 28. A frame is N+4 cells (2N+8 clocks). word_len is captured at frame start, and later changes have no effect on the frame in progress.
- R5: Each frame carries exactly N shift_stb pulses, each one clock long. The first falls in the first half of the third sync cell. The rest fall in the first half of every data cell except the last. ser_in is sampled at the end of the cell that holds the strobe.
- R6: The parity cell is encoded like a data cell. With odd_parity=0 the number of ones over the data bits and the parity bit is even. With odd_parity=1 it is odd. Sync is not counted. odd_parity is captured at frame start.
- R7: If enable is high when the parity cell ends, the next sync starts on the very next clock. Otherwise both line outputs return to 0 and stay there.
- R8: inhibit=1 forces line_one and line_zero to 0 in the same cycle. Frame timing and strobes carry on unchanged.
- R9: clk_div6 has a period of six clocks, three high and three low, and is low for the first three clocks after reset.
- R10: While a frame is active and inhibit is low, line_zero is the complement of line_one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Send clock, twice the bit rate |
| rst | input | 1 | Synchronous master reset, active high |
| enable | input | 1 | Start a frame, or keep frames running back to back |
| word_len | input | 5 | Data bit count N, clamped to 2..28 |
| sync_kind | input | 1 | 1 selects command-type sync, 0 selects data-type sync |
| odd_parity | input | 1 | 1 selects odd parity, 0 selects even |
| inhibit | input | 1 | Forces both line outputs inactive |
| ser_in | input | 1 | Serial data bit from external logic |
| shift_stb | output | 1 | Request for the next data bit |
| line_one | output | 1 | Positive biphase line output |
| line_zero | output | 1 | Complementary biphase line output |
| clk_div6 | output | 1 | Clock divided by six |

## Verification
The hardest case to reach from the ports is the seam between two frames. Here enable must still be high at the parity cell's last half, the next sync must begin with no idle cycle, and the serial-bit feed must restart for the new word. The bench reaches it by holding enable across a frame and checking that the second frame shows up on the very next half-cell. The other hard case is a change to the configuration inputs partway through a frame. The bench changes word_len, sync_kind and odd_parity after the sync has begun, and it pulses inhibit over random half-cell windows, so it can confirm that the captured settings and the cell timing survive both.

// File: rtl/mcenc_pkg.sv
package mcenc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SYNC = 2'd1,
      ST_DATA = 2'd2,
      ST_PAR  = 2'd3
   } enc_state_t;

   // Sync length in bit cells; its first half sits at one level, its second at the other.
   localparam int SYNC_CELLS = 3;

endpackage

// File: rtl/mcenc_clkdiv.sv
module mcenc_clkdiv #(
   parameter int DIV = 6
) (
   input  logic clk,
   input  logic rst,
   output logic half_ph,
   output logic div_out
);
   localparam int HALF   = DIV / 2;
   localparam int HCNT_W = (HALF > 2) ? $clog2(HALF) : 1;

   generate
      if ((DIV % 2) != 0 || DIV < 4) begin : g_bad_div
         $error("mcenc_clkdiv: DIV must be even and at least 4");
      end
   endgenerate

   logic [HCNT_W-1:0] hcnt;

   // Half-cell phase: 0 = first half of a bit cell, 1 = second half.
   always_ff @(posedge clk) begin
      if (rst) half_ph <= 1'b0;
      else     half_ph <= ~half_ph;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hcnt    <= '0;
         div_out <= 1'b0;
      end else if (hcnt == HCNT_W'(HALF - 1)) begin
         hcnt    <= '0;
         div_out <= ~div_out;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   // R9: once high, the divided clock stays high on the following cycle
   a_r9_div_hold: assert property (@(posedge clk) disable iff (rst)
      $rose(div_out) |=> div_out);

   // R9: once low, the divided clock stays low on the following cycle
   a_r9_div_low_hold: assert property (@(posedge clk) disable iff (rst)
      $fell(div_out) |=> !div_out);

endmodule

// File: rtl/mcenc_seq.sv
module mcenc_seq
   import mcenc_pkg::*;
#(
   parameter int LEN_W   = 5,
   parameter int MIN_LEN = 2,
   parameter int MAX_LEN = 28
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             half_ph,
   input  logic             enable,
   input  logic [LEN_W-1:0] len_cfg,
   input  logic             sync_sel,
   input  logic             odd_sel,
   input  logic             ser_in,
   output enc_state_t       state,
   output logic [LEN_W-1:0] cell_cnt,
   output logic             cell_bit,
   output logic             sync_pol,
   output logic             frame_active,
   output logic             shift_stb
);
   generate
      if (MIN_LEN < 1 || MIN_LEN > MAX_LEN) begin : g_bad_range
         $error("mcenc_seq: MIN_LEN must be at least 1 and no larger than MAX_LEN");
      end
      if (MAX_LEN >= (1 << LEN_W)) begin : g_bad_width
         $error("mcenc_seq: MAX_LEN does not fit in LEN_W bits");
      end
      if (SYNC_CELLS >= (1 << LEN_W)) begin : g_bad_sync
         $error("mcenc_seq: sync cell count does not fit the cell counter");
      end
   endgenerate

   localparam logic [LEN_W-1:0] LAST_SYNC = LEN_W'(SYNC_CELLS - 1);

   logic [LEN_W-1:0] len_eff;
   logic [LEN_W-1:0] len_q;
   logic             odd_q;
   logic             par_acc;
   logic             last_data;
   logic             cell_end;

   always_comb begin
      if (len_cfg < LEN_W'(MIN_LEN))      len_eff = LEN_W'(MIN_LEN);
      else if (len_cfg > LEN_W'(MAX_LEN)) len_eff = LEN_W'(MAX_LEN);
      else                                len_eff = len_cfg;
   end

   assign cell_end  = half_ph;
   assign last_data = (cell_cnt == (len_q - 1'b1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         cell_cnt <= '0;
         len_q    <= LEN_W'(MIN_LEN);
         sync_pol <= 1'b0;
         odd_q    <= 1'b0;
         cell_bit <= 1'b0;
         par_acc  <= 1'b0;
      end else if (cell_end) begin
         unique case (state)
            ST_IDLE: begin
               if (enable) begin
                  state    <= ST_SYNC;
                  cell_cnt <= '0;
                  len_q    <= len_eff;
                  sync_pol <= sync_sel;
                  odd_q    <= odd_sel;
                  par_acc  <= 1'b0;
               end
            end
            ST_SYNC: begin
               if (cell_cnt == LAST_SYNC) begin
                  state    <= ST_DATA;
                  cell_cnt <= '0;
                  cell_bit <= ser_in;
                  par_acc  <= ser_in;
               end else begin
                  cell_cnt <= cell_cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (last_data) begin
                  state    <= ST_PAR;
                  cell_bit <= par_acc ^ odd_q;
               end else begin
                  cell_cnt <= cell_cnt + 1'b1;
                  cell_bit <= ser_in;
                  par_acc  <= par_acc ^ ser_in;
               end
            end
            ST_PAR: begin
               if (enable) begin
                  state    <= ST_SYNC;
                  cell_cnt <= '0;
                  len_q    <= len_eff;
                  sync_pol <= sync_sel;
                  odd_q    <= odd_sel;
                  par_acc  <= 1'b0;
               end else begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign frame_active = (state != ST_IDLE);

   // One request per data bit: the first comes in the last sync cell, the rest in every data cell but the last.
   assign shift_stb = !half_ph &&
                      (((state == ST_SYNC) && (cell_cnt == LAST_SYNC)) ||
                       ((state == ST_DATA) && !last_data));

   // R5: a strobe never lasts more than one clock
   a_r5_one_clock_strobe: assert property (@(posedge clk) disable iff (rst)
      shift_stb |=> !shift_stb);

   // R4: the data cell counter stays below the captured word length
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DATA) |-> (cell_cnt < len_q));

   // R4: the captured length always lies inside the legal range
   a_r4_len_range: assert property (@(posedge clk) disable iff (rst)
      frame_active |-> (len_q >= LEN_W'(MIN_LEN) && len_q <= LEN_W'(MAX_LEN)));

   // R2: a frame always begins in the first half of a bit cell
   a_r2_start_boundary: assert property (@(posedge clk) disable iff (rst)
      $rose(frame_active) |-> !half_ph);

endmodule

// File: rtl/mcenc_line.sv
module mcenc_line
   import mcenc_pkg::*;
#(
   parameter int LEN_W          = 5,
   parameter bit OUT_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  enc_state_t       state,
   input  logic [LEN_W-1:0] cell_cnt,
   input  logic             half_ph,
   input  logic             cell_bit,
   input  logic             sync_pol,
   input  logic             inhibit,
   output logic             line_one,
   output logic             line_zero
);
   logic [LEN_W:0] sync_half;
   logic           lvl;
   logic           drive;
   logic           one_raw;
   logic           zero_raw;

   assign sync_half = {cell_cnt, half_ph};

   always_comb begin
      unique case (state)
         ST_SYNC: lvl = (sync_half < (LEN_W + 1)'(SYNC_CELLS)) ? sync_pol : ~sync_pol;
         ST_DATA,
         ST_PAR:  lvl = cell_bit ^ half_ph;
         default: lvl = 1'b0;
      endcase
   end

   assign drive    = (state != ST_IDLE) && !inhibit;
   assign one_raw  = drive & lvl;
   assign zero_raw = drive & ~lvl;

   generate
      if (OUT_ACTIVE_LOW) begin : g_act_low
         assign line_one  = ~one_raw;
         assign line_zero = ~zero_raw;
      end else begin : g_act_high
         assign line_one  = one_raw;
         assign line_zero = zero_raw;
      end
   endgenerate

   // R3: every data or parity cell changes level at its middle
   a_r3_midcell_flip: assert property (@(posedge clk) disable iff (rst)
      (half_ph && (state == ST_DATA || state == ST_PAR)) |-> (lvl != $past(lvl)));

   // R2: sync changes level exactly halfway through its three cells
   a_r2_sync_mid_flip: assert property (@(posedge clk) disable iff (rst)
      (half_ph && state == ST_SYNC && cell_cnt == LEN_W'(1)) |-> (lvl != $past(lvl)));

   // R2: sync holds its level across the first cell boundary
   a_r2_sync_first_hold: assert property (@(posedge clk) disable iff (rst)
      (!half_ph && state == ST_SYNC && cell_cnt == LEN_W'(1)) |-> (lvl == $past(lvl)));

endmodule

// File: rtl/manchester_frame_enc.sv
module manchester_frame_enc
   import mcenc_pkg::*;
#(
   parameter int LEN_W          = 5,
   parameter int MIN_LEN        = 2,
   parameter int MAX_LEN        = 28,
   parameter int AUX_DIV        = 6,
   parameter bit OUT_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   input  logic [LEN_W-1:0] word_len,
   input  logic             sync_kind,
   input  logic             odd_parity,
   input  logic             inhibit,
   input  logic             ser_in,
   output logic             shift_stb,
   output logic             line_one,
   output logic             line_zero,
   output logic             clk_div6
);
   logic             half_ph;
   enc_state_t       state;
   logic [LEN_W-1:0] cell_cnt;
   logic             cell_bit;
   logic             sync_pol;
   logic             frame_active;

   mcenc_clkdiv #(.DIV(AUX_DIV)) u_clkdiv (
      .clk     (clk),
      .rst     (rst),
      .half_ph (half_ph),
      .div_out (clk_div6)
   );

   mcenc_seq #(
      .LEN_W   (LEN_W),
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN)
   ) u_seq (
      .clk          (clk),
      .rst          (rst),
      .half_ph      (half_ph),
      .enable       (enable),
      .len_cfg      (word_len),
      .sync_sel     (sync_kind),
      .odd_sel      (odd_parity),
      .ser_in       (ser_in),
      .state        (state),
      .cell_cnt     (cell_cnt),
      .cell_bit     (cell_bit),
      .sync_pol     (sync_pol),
      .frame_active (frame_active),
      .shift_stb    (shift_stb)
   );

   mcenc_line #(
      .LEN_W          (LEN_W),
      .OUT_ACTIVE_LOW (OUT_ACTIVE_LOW)
   ) u_line (
      .clk       (clk),
      .rst       (rst),
      .state     (state),
      .cell_cnt  (cell_cnt),
      .half_ph   (half_ph),
      .cell_bit  (cell_bit),
      .sync_pol  (sync_pol),
      .inhibit   (inhibit),
      .line_one  (line_one),
      .line_zero (line_zero)
   );

   // R7: with no frame in progress both line outputs rest at their inactive level
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !frame_active |-> (line_one == OUT_ACTIVE_LOW && line_zero == OUT_ACTIVE_LOW));

   // R5: no data request is raised while idle
   a_r5_no_idle_strobe: assert property (@(posedge clk) disable iff (rst)
      !frame_active |-> !shift_stb);

endmodule

// File: tb/manchester_frame_enc_tb.sv
module manchester_frame_enc_tb;
   logic       clk = 1'b0;
   logic       rst;
   logic       enable;
   logic [4:0] word_len;
   logic       sync_kind;
   logic       odd_parity;
   logic       inhibit;
   logic       ser_in;
   logic       shift_stb;
   logic       line_one;
   logic       line_zero;
   logic       clk_div6;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   manchester_frame_enc u_dut (
      .clk        (clk),
      .rst        (rst),
      .enable     (enable),
      .word_len   (word_len),
      .sync_kind  (sync_kind),
      .odd_parity (odd_parity),
      .inhibit    (inhibit),
      .ser_in     (ser_in),
      .shift_stb  (shift_stb),
      .line_one   (line_one),
      .line_zero  (line_zero),
      .clk_div6   (clk_div6)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int clamp_len(input int raw);
      if (raw < 2)  return 2;
      if (raw > 28) return 28;
      return raw;
   endfunction

   function automatic logic exp_level(input logic [27:0] w, input int n, input logic kind,
                                      input logic oddp, input int h);
      int   c;
      logic sec;
      logic p;
      c   = h / 2;
      sec = logic'(h % 2);
      if (h < 6) return (h < 3) ? kind : ~kind;
      if (c < 3 + n) return w[n - 1 - (c - 3)] ^ sec;
      p = oddp;
      for (int i = 0; i < n; i++) p = p ^ w[i];
      return p ^ sec;
   endfunction

   // Waits for a frame (or expects it on the next half-cell when chained), then checks it half by half.
   task automatic do_frame(input logic [27:0] w, input int n, input logic kind, input logic oddp,
                           input bit chained, input bit keep_en, input int inh_lo,
                           input int inh_hi, input bit scramble);
      int   wait_n;
      bit   got;
      int   halves;
      int   strobes;
      int   stb_bad;
      int   sync_bad;
      int   data_bad;
      int   par_bad;
      int   comp_bad;
      int   inh_bad;
      int   idle_bad;
      int   bitp;
      logic el;
      halves = 2 * (n + 4);
      strobes = 0; stb_bad = 0; sync_bad = 0; data_bad = 0; par_bad = 0;
      comp_bad = 0; inh_bad = 0; idle_bad = 0; bitp = 0;
      got = 0; wait_n = 0;
      if (chained) begin
         @(negedge clk); #1;
         wait_n = 1;
         got = line_one | line_zero;
         check(got, "R7", "chained frame starts on next half-cell", int'(got), 1);
      end else begin
         while (!got && wait_n < 8) begin
            @(negedge clk); #1;
            wait_n++;
            got = line_one | line_zero;
         end
         check(got && wait_n <= 2, "R2", "clocks from enable to first sync half", wait_n, 2);
      end
      if (!got) return;
      if (!keep_en) enable = 1'b0;
      for (int h = 0; h < halves; h++) begin
         if (h > 0) begin
            @(negedge clk);
            inhibit = (h >= inh_lo && h < inh_hi);
            if (scramble && h == 3) begin
               word_len   = 5'($urandom);
               sync_kind  = ~kind;
               odd_parity = ~oddp;
            end
            #1;
         end
         el = exp_level(w, n, kind, oddp, h);
         if (inhibit) begin
            if (line_one || line_zero) inh_bad++;
         end else begin
            if (line_one == line_zero) comp_bad++;
            if (line_one != el) begin
               if (h < 6)               sync_bad++;
               else if (h < halves - 2) data_bad++;
               else                     par_bad++;
            end
         end
         if (shift_stb) begin
            if (h != 4 + 2 * strobes) stb_bad++;
            strobes++;
            ser_in = (bitp < n) ? w[n - 1 - bitp] : 1'b0;
            bitp++;
         end
      end
      inhibit = 1'b0;
      check(sync_bad == 0, "R2", "sync half-cells wrong", sync_bad, 0);
      check(data_bad == 0, "R3", "data half-cells wrong", data_bad, 0);
      check(par_bad == 0,  "R6", "parity half-cells wrong", par_bad, 0);
      check(comp_bad == 0, "R10", "outputs not complementary", comp_bad, 0);
      check(strobes == n,  "R5", "strobes per frame", strobes, n);
      check(stb_bad == 0,  "R5", "strobes at wrong half-cell", stb_bad, 0);
      if (inh_hi > inh_lo)
         check(inh_bad == 0, "R8", "output active while inhibited", inh_bad, 0);
      if (!keep_en) begin
         for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            if (line_one || line_zero || shift_stb) idle_bad++;
         end
         check(idle_bad == 0, "R4", "activity after 2N+8 half-cells", idle_bad, 0);
      end
   endtask

   task automatic setup(input int raw_len, input logic kind, input logic oddp);
      @(negedge clk);
      word_len   = 5'(raw_len);
      sync_kind  = kind;
      odd_parity = oddp;
      enable     = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int   raw;
      int   n;
      logic [27:0] w;
      logic k;
      logic o;
      int   lo;
      int   len;
      logic prev;
      int   bad;
      void'($urandom(32'd5531));
      rst = 1'b1; enable = 1'b0; word_len = 5'd8; sync_kind = 1'b0;
      odd_parity = 1'b0; inhibit = 1'b0; ser_in = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      check(!line_one && !line_zero && !shift_stb && !clk_div6, "R1", "outputs during reset",
            int'({line_one, line_zero, shift_stb, clk_div6}), 0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk); #1;
      check(!line_one && !line_zero && !shift_stb && !clk_div6, "R1", "outputs after reset",
            int'({line_one, line_zero, shift_stb, clk_div6}), 0);

      // R9: divide-by-six waveform
      prev = clk_div6;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); #1;
         if (!prev && clk_div6) break;
         prev = clk_div6;
      end
      bad = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); #1;
         if (clk_div6 != ((i < 2 || i == 5) ? 1'b1 : 1'b0)) bad++;
      end
      check(bad == 0, "R9", "div6 pattern mismatches", bad, 0);

      // R3 R6: shortest word, command sync, even parity
      setup(2, 1'b1, 1'b0);
      do_frame(28'b10, 2, 1'b1, 1'b0, 0, 0, 0, 0, 0);
      // R4: longest word, data sync, odd parity
      setup(28, 1'b0, 1'b1);
      do_frame(28'hA5C3_96E, 28, 1'b0, 1'b1, 0, 0, 0, 0, 0);
      // R4: out-of-range lengths clamp
      setup(0, 1'b1, 1'b1);
      do_frame(28'b01, 2, 1'b1, 1'b1, 0, 0, 0, 0, 0);
      setup(1, 1'b0, 1'b0);
      do_frame(28'b11, 2, 1'b0, 1'b0, 0, 0, 0, 0, 0);
      setup(31, 1'b1, 1'b0);
      do_frame(28'hFFF_FFFF, 28, 1'b1, 1'b0, 0, 0, 0, 0, 0);
      // R6: all-zero word with odd parity
      setup(16, 1'b0, 1'b1);
      do_frame(28'h0, 16, 1'b0, 1'b1, 0, 0, 0, 0, 0);
      // R8: inhibit across sync and data
      setup(10, 1'b1, 1'b0);
      do_frame(28'h2B5, 10, 1'b1, 1'b0, 0, 0, 2, 11, 0);
      // R4 R2 R6: configuration changed mid-frame has no effect
      setup(12, 1'b1, 1'b1);
      do_frame(28'hC3A, 12, 1'b1, 1'b1, 0, 0, 0, 0, 1);
      // R7: back-to-back frames
      setup(6, 1'b0, 1'b0);
      do_frame(28'h2D, 6, 1'b0, 1'b0, 0, 1, 0, 0, 0);
      do_frame(28'h17, 6, 1'b0, 1'b0, 1, 0, 0, 0, 0);

      // R1: reset in the middle of a frame
      setup(20, 1'b1, 1'b0);
      for (int i = 0; i < 8 && !(line_one || line_zero); i++) begin
         @(negedge clk); #1;
      end
      repeat (9) @(negedge clk);
      enable = 1'b0;
      rst = 1'b1;
      @(negedge clk); #1;
      check(!line_one && !line_zero && !shift_stb, "R1", "reset aborts frame",
            int'({line_one, line_zero, shift_stb}), 0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      check(!line_one && !line_zero, "R1", "idle after mid-frame reset",
            int'({line_one, line_zero}), 0);

      // Random frames
      for (int t = 0; t < 14; t++) begin
         raw = int'($urandom_range(0, 31));
         n   = clamp_len(raw);
         w   = 28'($urandom);
         k   = 1'($urandom);
         o   = 1'($urandom);
         lo  = 0; len = 0;
         if ($urandom_range(0, 2) == 0) begin
            lo  = int'($urandom_range(1, 2 * (n + 4) - 1));
            len = int'($urandom_range(1, 5));
         end
         setup(raw, k, o);
         do_frame(w, n, k, o, 0, 0, lo, lo + len, bit'($urandom_range(0, 1)));
      end

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule